// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog that counts ticks of its own free-running oscillator, which reaches the block as a one-cycle enable `tick_i` in the system clock domain. A prescaler divides the ticks by 2^PRE_W (2048 by default) and drives an 8-bit up-counter. When the counter wraps past its all-ones value, the block raises a one-cycle reset request and a stretched reset pulse of PULSE_UNITS prescaler periods.

A byte-wide control register works as a key. The value A5h stops the watchdog and holds the prescaler and counter at zero, and it is the value after reset. Any other value lets the watchdog run. Software reloads the counter in two steps. It first writes the arming key 5Ah to the control register, then writes the new counter value. An accepted reload clears the prescaler and sets the control register to 00h. The watchdog therefore stays running and the key has to be written again before the next reload.

CPU writes are held in a pending slot and take effect on the next tick. Reads return the live counter or control value at any time.

Top module: `keyed_wdt`

## Requirements
- R1: After rst_ni the control register reads A5h, the counter reads 00h, and rst_req_o and rst_pulse_o are low.
- R2: While the control register is not A5h, the counter advances by one every 2^PRE_W ticks. It can be read (rd_sel_i=1) while it runs.
- R3: While the control register holds A5h, the prescaler and counter are cleared and do not count.
- R4: A counter write (wr_sel_i=1) is ignored unless the control register holds 5Ah. When it is ignored, the counter and the control register keep their values.
- R5: An accepted counter write loads the written value, clears the prescaler and sets the control register to 00h.
- R6: After a load of value V, the overflow happens on tick 2^PRE_W*(256-V). rst_req_o is then high for exactly one clock cycle.
- R7: On overflow, rst_pulse_o goes high for PULSE_UNITS*2^PRE_W ticks. The reset it generates does not cut the pulse short. The control register returns to A5h and the counter to 00h.
- R8: A write (wr_sel_i=0 selects the control register, 1 selects the counter) takes effect only on the next tick. If several writes arrive before that tick, the latest one wins.
- R9: Writes issued while rst_pulse_o is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per oscillator tick |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 counter |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read source: 0 control, 1 counter |
| rd_data_o | output | 8 | Read data |
| rst_req_o | output | 1 | One-cycle reset request on overflow |
| rst_pulse_o | output | 1 | Stretched reset pulse |

## Verification
The hardest case to reach from the ports is the exact overflow boundary. It needs a keyed reload at a known prescaler phase, followed by a run to the final count with no tick lost or added. The bench drives every tick itself and stops ticks during bus writes, so it always knows the prescaler phase. It then loads F0h and checks one tick before the overflow and at the overflow. The pulse is measured the same way, and a write is issued in the middle of the pulse to show it is blocked.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_OFF = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_ARM = 8'h5A;
  localparam logic [DATA_W-1:0] KEY_RUN = 8'h00;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_CNT  = 1'b1
  } wdt_sel_e;
endpackage

// File: rtl/wdt_write_sync.sv
module wdt_write_sync
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              apply_ctrl_o,
  output logic              apply_cnt_o,
  output logic [DATA_W-1:0] apply_data_o
);
  logic              pend_q;
  wdt_sel_e          sel_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sel_q  <= SEL_CTRL;
      data_q <= '0;
    end else if (wr_en_i && !hold_i) begin
      pend_q <= 1'b1;
      sel_q  <= wdt_sel_e'(wr_sel_i);
      data_q <= wr_data_i;
    end else if (tick_i) begin
      pend_q <= 1'b0;
    end
  end

  assign apply_ctrl_o = pend_q && tick_i && (sel_q == SEL_CTRL);
  assign apply_cnt_o  = pend_q && tick_i && (sel_q == SEL_CNT);
  assign apply_data_o = data_q;

  p_no_apply_without_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !tick_i |=> pend_q);
endmodule

// File: rtl/wdt_key_reg.sv
module wdt_key_reg
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_ctrl_i,
  input  logic              apply_cnt_i,
  input  logic [DATA_W-1:0] apply_data_i,
  input  logic              ovf_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              off_o,
  output logic              load_o
);
  logic [DATA_W-1:0] ctrl_q;

  assign load_o = apply_cnt_i && (ctrl_q == KEY_ARM) && !ovf_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ctrl_q <= KEY_OFF;
    else if (ovf_i || hold_i)        ctrl_q <= KEY_OFF;
    else if (load_o)                 ctrl_q <= KEY_RUN;
    else if (apply_ctrl_i)           ctrl_q <= apply_data_i;
  end

  assign ctrl_o = ctrl_q;
  assign off_o  = (ctrl_q == KEY_OFF);

  p_unkeyed_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_cnt_i && (ctrl_q != KEY_ARM) && !ovf_i && !hold_i |=> ctrl_q == $past(ctrl_q));
  p_load_clears_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> ctrl_q == KEY_RUN);
  p_hold_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ctrl_q == KEY_OFF);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              off_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_o
);
  localparam int unsigned TOT_W = DATA_W + PRE_W;

  logic [TOT_W-1:0] acc_q;

  assign ovf_o = tick_i && !off_i && (&acc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (off_i)   acc_q <= '0;
    else if (load_i)  acc_q <= {load_data_i, {PRE_W{1'b0}}};
    else if (tick_i)  acc_q <= acc_q + TOT_W'(1);
  end

  assign cnt_o = acc_q[TOT_W-1:PRE_W];

  p_off_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> acc_q == '0);
  p_idle_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !off_i && !load_i |=> $stable(acc_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PRE_W       = 11,
  parameter int unsigned PULSE_UNITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ovf_i,
  output logic req_o,
  output logic active_o
);
  localparam int unsigned PW   = $clog2(PULSE_UNITS) + PRE_W;
  localparam int unsigned PLEN = PULSE_UNITS << PRE_W;

  logic          act_q;
  logic          req_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      req_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      req_q <= ovf_i;
      if (ovf_i) begin
        act_q  <= 1'b1;
        pcnt_q <= '0;
      end else if (act_q && tick_i) begin
        if (pcnt_q == PW'(PLEN - 1)) begin
          act_q  <= 1'b0;
          pcnt_q <= '0;
        end else begin
          pcnt_q <= pcnt_q + PW'(1);
        end
      end
    end
  end

  assign req_o    = req_q;
  assign active_o = act_q;

  p_req_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  p_pulse_from_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(ovf_i));
  p_pulse_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !tick_i |=> act_q);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W       = 11,
  parameter int unsigned PULSE_UNITS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_sel_i,
  output logic [7:0] rd_data_o,
  output logic       rst_req_o,
  output logic       rst_pulse_o
);
  logic              apply_ctrl, apply_cnt, off, load, ovf, hold;
  logic [DATA_W-1:0] apply_data, ctrl, cnt;

  wdt_write_sync u_sync (
    .clk_i, .rst_ni, .tick_i, .hold_i(hold), .wr_en_i, .wr_sel_i, .wr_data_i,
    .apply_ctrl_o(apply_ctrl), .apply_cnt_o(apply_cnt), .apply_data_o(apply_data)
  );

  wdt_key_reg u_key (
    .clk_i, .rst_ni, .apply_ctrl_i(apply_ctrl), .apply_cnt_i(apply_cnt),
    .apply_data_i(apply_data), .ovf_i(ovf), .hold_i(hold),
    .ctrl_o(ctrl), .off_o(off), .load_o(load)
  );

  wdt_counter #(.PRE_W(PRE_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .off_i(off), .load_i(load),
    .load_data_i(apply_data), .cnt_o(cnt), .ovf_o(ovf)
  );

  wdt_pulse #(.PRE_W(PRE_W), .PULSE_UNITS(PULSE_UNITS)) u_pulse (
    .clk_i, .rst_ni, .tick_i, .ovf_i(ovf), .req_o(rst_req_o), .active_o(hold)
  );

  assign rd_data_o   = (wdt_sel_e'(rd_sel_i) == SEL_CNT) ? cnt : ctrl;
  assign rst_pulse_o = hold;

  p_ovf_disarms_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> (ctrl == KEY_OFF) && rst_pulse_o);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int unsigned PRE_W = 3;
  localparam int unsigned UNITS = 16;
  localparam int unsigned STEP  = 1 << PRE_W;
  localparam int unsigned PLEN  = UNITS * STEP;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic       req, pulse;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  keyed_wdt #(.PRE_W(PRE_W), .PULSE_UNITS(UNITS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .rst_req_o(req), .rst_pulse_o(pulse)
  );

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req_tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string req_tag);
    rd_sel = sel;
    #1;
    chk(req_tag, rd_data, exp);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic cpu_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    rd(1'b0, 8'hA5, "R1");
    rd(1'b1, 8'h00, "R1");
    chk("R1", {7'd0, req}, 8'd0);
    chk("R1", {7'd0, pulse}, 8'd0);
  endtask

  task automatic t_tick_gated_write;
    cpu_wr(1'b0, 8'h00);
    repeat (5) @(negedge clk);
    rd(1'b0, 8'hA5, "R8");
    wait_ticks(1);
    rd(1'b0, 8'h00, "R8");
  endtask

  task automatic t_count;
    wait_ticks(5 * STEP - 1);
    rd(1'b1, 8'h04, "R2");
    wait_ticks(1);
    rd(1'b1, 8'h05, "R2");
  endtask

  task automatic t_unkeyed;
    cpu_wr(1'b1, 8'hF0);
    wait_ticks(1);
    rd(1'b1, 8'h05, "R4");
    rd(1'b0, 8'h00, "R4");
  endtask

  task automatic t_keyed_reload;
    cpu_wr(1'b0, 8'h11);
    cpu_wr(1'b0, 8'h5A);
    wait_ticks(1);
    rd(1'b0, 8'h5A, "R8");
    cpu_wr(1'b1, 8'hF0);
    wait_ticks(1);
    rd(1'b1, 8'hF0, "R5");
    rd(1'b0, 8'h00, "R5");
  endtask

  task automatic t_timeout;
    wait_ticks(STEP * 16 - 1);
    rd(1'b1, 8'hFF, "R6");
    chk("R6", {7'd0, pulse}, 8'd0);
    chk("R6", {7'd0, req}, 8'd0);
    wait_ticks(1);
    chk("R6", {7'd0, req}, 8'd1);
    chk("R7", {7'd0, pulse}, 8'd1);
    @(negedge clk);
    chk("R6", {7'd0, req}, 8'd0);
    rd(1'b0, 8'hA5, "R7");
    rd(1'b1, 8'h00, "R7");
  endtask

  task automatic t_pulse;
    cpu_wr(1'b0, 8'h00);
    wait_ticks(1);
    rd(1'b0, 8'hA5, "R9");
    wait_ticks(PLEN - 2);
    chk("R7", {7'd0, pulse}, 8'd1);
    wait_ticks(1);
    chk("R7", {7'd0, pulse}, 8'd0);
    rd(1'b0, 8'hA5, "R7");
    rd(1'b1, 8'h00, "R7");
  endtask

  task automatic t_disable;
    cpu_wr(1'b0, 8'h00);
    wait_ticks(1);
    wait_ticks(2 * STEP + 4);
    rd(1'b1, 8'h02, "R2");
    cpu_wr(1'b0, 8'hA5);
    wait_ticks(1);
    rd(1'b0, 8'hA5, "R3");
    wait_ticks(3 * STEP);
    rd(1'b1, 8'h00, "R3");
    chk("R3", {7'd0, pulse}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tick_gated_write();
    t_count();
    t_unkeyed();
    t_keyed_reload();
    t_timeout();
    t_pulse();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule